// File: doc/BRIEF.md
# Serial Tune Select and Playback Gate

This block sits between a host controller and a melody sequencer. The host picks a tune by clocking bits in over a two-wire serial port, one data line and one shift clock. Only the most recent four bits count, and they form the tune index the sequencer reads. A level-sensitive start input controls playback. While start is high, the block opens the reference-clock enable at once. After a fixed startup delay it raises the sequencer's play enable. The moment start falls, both enables drop.

While start is high the serial port is locked, so a tune that is playing cannot be changed. The selected index survives a stop and is reused on the next start. The serial clock must be low whenever start changes level. If the host breaks this rule, a sticky protocol-error flag is set. All inputs are assumed to be already synchronised to `clk`.

Top module: `tune_sel_ctrl`

## Requirements
- R1: On a cycle where the shift clock is seen rising (high now, low on the previous edge) and start is low, the data bit enters index bit 0 and the other bits move up one place. Bits older than the last four are lost, so after a 7-bit stream the index equals the final four bits.
- R2: The stream is sent most significant bit first: after four shifts carrying B3, B2, B1, B0, index bit 3 holds B3 and bit 0 holds B0. The index keeps its value through playback and after start falls.
- R3: Shift-clock rising edges that are sampled while start is high leave the tune index unchanged.
- R4: Play enable is low whenever start is low, including in the same cycle that start falls.
- R5: Play enable is high once start has been sampled high on START_DELAY (default 128) consecutive clock edges. It stays low after START_DELAY-1 such edges.
- R6: The clock-gate enable follows start directly: high while start is high and low while it is low.
- R7: A change of level on start while the shift clock is high sets the protocol-error flag. The flag stays set until reset.
- R8: One sampled low cycle on start restarts the startup delay, so two high periods shorter than START_DELAY never raise play enable.
- R9: After synchronous active-low reset, the tune index is 0, play enable is 0 and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial tune-select data |
| ser_clk | input | 1 | Serial shift clock, sampled as a level |
| start | input | 1 | Playback request level |
| tune_idx | output | 4 | Latched tune index |
| clk_gate_en | output | 1 | Reference-clock gate enable |
| play_en | output | 1 | Sequencer play enable |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Two functions can fall in the same cycle: the serial lockout and the protocol guard. If the shift clock rises in the same cycle that start rises, that edge would be a shift, but it is also a rule violation. The bench provokes this by raising both inputs together after loading a known index. It then expects the index to stay unchanged, because the lockout wins, and the error flag to be set, because the guard still fires. A separate sweep loads all sixteen indices through 7-bit streams before this case is run.

// File: rtl/tune_sel_pkg.sv
// Shared constants for the tune-select controller.
package tune_sel_pkg;
    localparam int TUNE_W_DEF      = 4;
    localparam int START_DELAY_DEF = 128;
endpackage

// File: rtl/tsc_shift.sv
// Serial shifter: detects rising edges of the sampled shift clock and moves
// data in, least significant end first in position, so a stream sent MSB first
// ends up in natural order. Assumes inputs are synchronous to clk.
module tsc_shift #(
    parameter int TUNE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              lock,
    output logic [TUNE_W-1:0] idx
);
    logic              sclk_q;
    logic              shift_go;
    logic [TUNE_W-1:0] idx_q;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= ser_clk;
    end

    assign shift_go = ser_clk && !sclk_q && !lock;

    // Bit 0 takes the fresh data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q[0] <= 1'b0;
        else if (shift_go) idx_q[0] <= ser_data;
    end

    // Upper bits each take their lower neighbour.
    for (genvar b = 1; b < TUNE_W; b++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)        idx_q[b] <= 1'b0;
            else if (shift_go) idx_q[b] <= idx_q[b-1];
        end
    end

    assign idx = idx_q;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(idx_q)); // R3
    AST_FRESH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !sclk_q && !lock) |=> idx_q[0] == $past(ser_data)); // R1
endmodule

// File: rtl/tsc_timer.sv
// Startup timer: counts clock edges with start high, saturating at the delay.
// Play enable is combinational with start, so a stop is immediate. A single
// sampled low cycle clears the count.
module tsc_timer #(
    parameter int START_DELAY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic play_en
);
    localparam int CNT_W = $clog2(START_DELAY + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(START_DELAY);

    logic [CNT_W-1:0] cnt;

    // Count high cycles up to the limit; clear on any low sample.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!start)     cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign play_en = start && (cnt == LIMIT);

    AST_PLAY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        play_en |-> start); // R4
    AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_en) |-> $past(start)); // R8
endmodule

// File: rtl/tsc_guard.sv
// Protocol guard: flags a start level change while the shift clock is high.
// The flag is sticky until reset.
module tsc_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ser_clk,
    output logic err
);
    logic start_q;
    logic err_q;

    // Track the previous start level.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Set the flag on a violation and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= 1'b0;
        else if ((start != start_q) && ser_clk)   err_q <= 1'b1;
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R7
endmodule

// File: rtl/tune_sel_ctrl.sv
// Top: serial tune select with playback lockout, clock gating and delayed
// sequencer enable. Inputs are assumed synchronised to clk.
module tune_sel_ctrl
    import tune_sel_pkg::*;
#(
    parameter int TUNE_W      = TUNE_W_DEF,
    parameter int START_DELAY = START_DELAY_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              start,
    output logic [TUNE_W-1:0] tune_idx,
    output logic              clk_gate_en,
    output logic              play_en,
    output logic              proto_err
);
    tsc_shift #(.TUNE_W(TUNE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .lock(start), .idx(tune_idx)
    );

    tsc_timer #(.START_DELAY(START_DELAY)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .play_en(play_en)
    );

    tsc_guard u_guard (
        .clk(clk), .rst_n(rst_n), .start(start), .ser_clk(ser_clk),
        .err(proto_err)
    );

    // The gate is opened by the start level alone.
    assign clk_gate_en = start;

    AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> !clk_gate_en); // R6
    AST_PLAY_IMPLIES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        play_en |-> clk_gate_en); // R4
endmodule

// File: tb/tune_sel_ctrl_bench.sv
module tune_sel_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic ser_clk = 1'b0;
    logic start = 1'b0;
    logic [3:0] tune_idx;
    logic clk_gate_en, play_en, proto_err;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tune_sel_ctrl u_tune_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .start(start), .tune_idx(tune_idx), .clk_gate_en(clk_gate_en),
        .play_en(play_en), .proto_err(proto_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        ser_data = b; ser_clk = 1'b1; tick();
        ser_clk = 1'b0; tick();
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        // R9 reset state
        chk("R9 idx", int'(tune_idx), 0);
        chk("R9 play", int'(play_en), 0);
        chk("R9 err", int'(proto_err), 0);
        rst_n = 1'b1; tick();

        // R1 R2 sweep: 7-bit streams, the last four are the index (MSB first)
        for (int v = 0; v < 16; v++) begin
            int pre = (v * 5 + 3) % 8;
            for (int i = 2; i >= 0; i--) shift_bit(pre[i]);
            for (int i = 3; i >= 0; i--) shift_bit(v[i]);
            chk("R1 R2 sweep idx", int'(tune_idx), v);
        end

        // R5 R6 startup delay, index 4'b1010 loaded
        for (int i = 3; i >= 0; i--) shift_bit(4'hA >> i);
        start = 1'b1; #1;
        chk("R6 gate on", int'(clk_gate_en), 1);
        for (int k = 1; k <= 127; k++) tick();
        chk("R5 play after 127", int'(play_en), 0);
        tick();
        chk("R5 play after 128", int'(play_en), 1);

        // R3 shifts during playback ignored
        for (int i = 0; i < 6; i++) shift_bit(i[0]);
        chk("R3 idx locked", int'(tune_idx), 10);
        chk("R5 still playing", int'(play_en), 1);

        // R4 R6 immediate stop; R2 index retained
        start = 1'b0; #1;
        chk("R4 play drops", int'(play_en), 0);
        chk("R6 gate off", int'(clk_gate_en), 0);
        tick();
        chk("R2 idx retained", int'(tune_idx), 10);

        // R8 short pulses with a one-cycle gap
        start = 1'b1;
        for (int k = 0; k < 100; k++) tick();
        start = 1'b0; tick();
        chk("R8 gap play", int'(play_en), 0);
        start = 1'b1;
        for (int k = 0; k < 100; k++) tick();
        chk("R8 no early play", int'(play_en), 0);
        for (int k = 0; k < 28; k++) tick();
        chk("R8 full run plays", int'(play_en), 1);
        start = 1'b0; tick();
        chk("R7 no err yet", int'(proto_err), 0);

        // R3 R7 collision: shift clock rises with start
        for (int i = 3; i >= 0; i--) shift_bit(4'h5 >> i);
        ser_data = 1'b1; ser_clk = 1'b1; start = 1'b1; tick();
        ser_clk = 1'b0; tick();
        chk("R3 collision idx", int'(tune_idx), 5);
        chk("R7 err set", int'(proto_err), 1);
        start = 1'b0; tick(); tick();
        chk("R7 err sticky", int'(proto_err), 1);

        // R9 reset clears flag, index
        rst_n = 1'b0; tick();
        chk("R9 err cleared", int'(proto_err), 0);
        chk("R9 idx cleared", int'(tune_idx), 0);
        rst_n = 1'b1; tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule